// File: doc/BRIEF.md
# Rescheduled Sub-Section Triangular Spread Modulator

This block produces the frequency-spreading offset that a DCO code generator applies around a locked center code. One modulation period is cut into COUNT sub-sections of equal length. During each sub-section the block presents one constant offset, a signed whole multiple of a spreading step S. The offset is given as a direction flag and a 16-bit magnitude. The sub-sections are not played in plain triangle order. They are grouped in fours. Each group sums to zero, and neighbouring offsets never differ by more than (COUNT/4 + 1)·S.

A second output, the tracking window, goes high for one cycle at the start of every group of four sub-sections. At that point the net phase drift of the completed group is zero, so the phase loop may correct several times per modulation period. COUNT is chosen by a 3-bit section select and S by a 3-bit step select. The sub-section length is a parameter given in reference-clock cycles. With modulation disabled the block outputs no offset and holds the tracking window open.

Top module: `spread_tri_mod`

## Requirements
- R1: Reset is synchronous and active low. On the first edge with `rst_n` low the outputs become `step_mag`=0, `step_dir`=0 and `track_en`=1. The first edge after release with `mod_en` high starts sub-section 0.
- R2: `sec_sel` selects COUNT: 0 gives 8, 1 gives 16, 2 gives 32, and any value from 3 to 7 gives 64. The index wraps from COUNT−1 back to 0.
- R3: `step_sel` selects S = 1 << `step_sel`. `step_mag` equals |level|·S. `step_dir` is 1 when the level is negative (subtract from the code) and 0 when it is positive (add). The level is never zero while running.
- R4: With K = COUNT/4, h = floor(n/8), p = K−h and q = h+1, sub-section n has level +p when n mod 4 = 0, −q when it is 1, −p when it is 2, and +q when it is 3. Its magnitude never exceeds K.
- R5: Each sub-section lasts DWELL cycles. The outputs are registered. The value seen after the k-th enabled edge (counting from 0) belongs to sub-section floor(k/DWELL) mod COUNT.
- R6: The largest offset change between consecutive sub-sections, including the wrap from last to first, is exactly (K+1)·S: 3S, 5S, 9S and 17S for the four counts.
- R7: The offsets of sub-sections 4j to 4j+3 sum to zero for every group j, so a whole period has zero mean.
- R8: While running, `track_en` is 1 only in the first cycle of sub-sections whose index is a multiple of 4. That gives COUNT/4 one-cycle pulses per period.
- R9: When `mod_en` is low at an edge, the next outputs are `step_mag`=0, `step_dir`=0 and `track_en`=1, whatever `sec_sel` and `step_sel` hold. Re-enabling restarts at sub-section 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Spreading enable |
| sec_sel | input | 3 | Sub-section count select |
| step_sel | input | 3 | Spreading step select (power-of-two exponent) |
| step_dir | output | 1 | 1 = subtract offset from code, 0 = add |
| step_mag | output | 16 | Offset magnitude in code units |
| track_en | output | 1 | Phase-tracking window |

## Verification
The bench sweeps every section select with every step select over two full periods. It compares each cycle's signed offset with the closed-form level. A reordering slip or a dropped sign would show there, and a wrong magnitude would also break the zero sum of a group. It measures the largest neighbour jump, wrap included, and requires it to equal (K+1)·S exactly. A design that played the plain division order would give a larger jump, and one with a shifted level table would give a smaller one. Tracking pulses are checked for position and per-period count, which catches windows placed mid-group or off by one cycle. Idle, select changes while idle, and reset in the middle of a run are checked to confirm that a restart always begins at sub-section 0.

// File: rtl/ssm_pkg.sv
// Shared widths and types of the spread modulator.
// Assumes MIN_LOG2 >= 2 so that every count splits into groups of four.
package ssm_pkg;
    localparam int SEL_W    = 3;                   // section select width
    localparam int SHIFT_W  = 3;                   // step select width
    localparam int MAG_W    = 16;                  // offset magnitude width
    localparam int MIN_LOG2 = 3;                   // smallest count = 8
    localparam int MAX_LOG2 = 6;                   // largest count = 64
    localparam int IDX_W    = MAX_LOG2;            // sub-section index width
    localparam int LVL_W    = MAX_LOG2 - 1;        // holds K = COUNT/4 up to max

    // Signed level in units of S, stored as sign and magnitude
    typedef struct packed {
        logic             neg;
        logic [LVL_W-1:0] mag;
    } level_t;
endpackage

// File: rtl/ssm_cfg_decode.sv
// Decodes the section select into K (= COUNT/4) and the last index,
// and passes the step exponent through. Selects above the largest
// supported count saturate to it. Purely combinational.
module ssm_cfg_decode
    import ssm_pkg::*;
(
    input  logic [SEL_W-1:0]   sec_sel,
    input  logic [SHIFT_W-1:0] step_sel,
    output logic [LVL_W-1:0]   k_val,
    output logic [IDX_W-1:0]   last_idx,
    output logic [SHIFT_W-1:0] step_sh
);
    localparam int N_SEL = 2 ** SEL_W;

    logic [LVL_W-1:0] k_tab    [N_SEL];
    logic [IDX_W-1:0] last_tab [N_SEL];

    // One table entry per select code, saturating at MAX_LOG2
    for (genvar s = 0; s < N_SEL; s++) begin : g_tab
        localparam int LG = (MIN_LOG2 + s > MAX_LOG2) ? MAX_LOG2 : MIN_LOG2 + s;
        assign k_tab[s]    = LVL_W'(1 << (LG - 2));
        assign last_tab[s] = IDX_W'((1 << LG) - 1);
    end

    assign k_val    = k_tab[sec_sel];
    assign last_idx = last_tab[sec_sel];
    assign step_sh  = step_sel;
endmodule

// File: rtl/ssm_seq.sv
// Sub-section sequencer: counts DWELL cycles per sub-section and steps
// the index through 0..last_idx. While disabled it parks on the last
// dwell cycle with an all-ones index, so the first enabled edge lands
// on sub-section 0 and opens a group. The next-state index is exported
// so that the output stage registers values aligned with the state.
module ssm_seq
    import ssm_pkg::*;
#(
    parameter int DWELL = 16
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx_nxt,
    output logic             grp_start_nxt,
    output logic [IDX_W-1:0] idx_q,
    output logic             first_q,
    output logic             active_q
);
    logic dwell_end;

    if (DWELL > 1) begin : g_cnt
        localparam int CNT_W = $clog2(DWELL);
        localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);
        logic [CNT_W-1:0] cnt_q;

        // Dwell counter, parked on its last value when idle
        always_ff @(posedge clk) begin : p_cnt
            if (!rst_n || !en)          cnt_q <= CNT_LAST;
            else if (cnt_q == CNT_LAST) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
        end

        assign dwell_end = (cnt_q == CNT_LAST);
        assign first_q   = (cnt_q == '0);
    end else begin : g_nocnt
        assign dwell_end = 1'b1;
        assign first_q   = 1'b1;
    end

    // Next sub-section index with wrap at the selected count
    always_comb begin : p_idx_next
        if (!en)                    idx_nxt = '1;
        else if (!dwell_end)        idx_nxt = idx_q;
        else if (idx_q >= last_idx) idx_nxt = '0;
        else                        idx_nxt = idx_q + 1'b1;
    end

    assign grp_start_nxt = en && dwell_end && (idx_nxt[1:0] == 2'b00);

    // Index and running-flag registers
    always_ff @(posedge clk) begin : p_state
        if (!rst_n) begin
            idx_q    <= '1;
            active_q <= 1'b0;
        end else begin
            idx_q    <= idx_nxt;
            active_q <= en;
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && !first_q) |-> (idx_q == $past(idx_q))); // R5
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !$past(active_q)) |-> (idx_q == '0 && first_q)); // R9
endmodule

// File: rtl/ssm_level.sv
// Maps a sub-section index to its rescheduled level. Group g = idx/4
// plays +p, -q, -p, +q with h = g/2, p = K-h, q = h+1, so every group
// sums to zero and p+q = K+1 bounds every neighbour jump. Combinational.
// Assumes idx < 4K when the result is used.
module ssm_level
    import ssm_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [LVL_W-1:0] k_val,
    output level_t           lvl
);
    logic [LVL_W-1:0] h, p, q;

    // Pair magnitudes and pick the signed member for this slot
    always_comb begin : p_level
        h = LVL_W'(idx[IDX_W-1:3]);
        p = k_val - h;
        q = h + 1'b1;
        unique case (idx[1:0])
            2'd0: begin lvl.neg = 1'b0; lvl.mag = p; end
            2'd1: begin lvl.neg = 1'b1; lvl.mag = q; end
            2'd2: begin lvl.neg = 1'b1; lvl.mag = p; end
            default: begin lvl.neg = 1'b0; lvl.mag = q; end
        endcase
    end
endmodule

// File: rtl/ssm_outreg.sv
// Output stage: scales the level by S = 1 << step_sh and registers the
// direction, magnitude and tracking window. Idle or reset forces zero
// offset with the window held open.
// Assumes LVL_W + 2**SHIFT_W - 1 <= MAG_W, so the scaling never overflows.
module ssm_outreg
    import ssm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  level_t             lvl,
    input  logic [SHIFT_W-1:0] step_sh,
    input  logic               grp_start,
    output logic               dir_q,
    output logic [MAG_W-1:0]   mag_q,
    output logic               track_q
);
    logic [MAG_W-1:0] mag_scaled;

    assign mag_scaled = MAG_W'(lvl.mag) << step_sh;

    // Register the offset and the tracking window
    always_ff @(posedge clk) begin : p_out
        if (!rst_n || !en) begin
            dir_q   <= 1'b0;
            mag_q   <= '0;
            track_q <= 1'b1;
        end else begin
            dir_q   <= lvl.neg;
            mag_q   <= mag_scaled;
            track_q <= grp_start;
        end
    end
endmodule

// File: rtl/spread_tri_mod.sv
// Rescheduled sub-section triangular spread modulator (top).
// Produces a sign/magnitude code offset per sub-section and a tracking
// window at every group of four sub-sections. DWELL is the sub-section
// length in reference cycles (>= 1). Outputs are registered.
module spread_tri_mod
    import ssm_pkg::*;
#(
    parameter int DWELL = 16
)
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mod_en,
    input  logic [SEL_W-1:0]   sec_sel,
    input  logic [SHIFT_W-1:0] step_sel,
    output logic               step_dir,
    output logic [MAG_W-1:0]   step_mag,
    output logic               track_en
);
    logic [LVL_W-1:0]   k_val;
    logic [IDX_W-1:0]   last_idx, idx_nxt, idx_q;
    logic [SHIFT_W-1:0] step_sh;
    logic               grp_start_nxt, first_q, active;
    level_t             lvl;

    ssm_cfg_decode u_dec (
        .sec_sel  (sec_sel),
        .step_sel (step_sel),
        .k_val    (k_val),
        .last_idx (last_idx),
        .step_sh  (step_sh)
    );

    ssm_seq #(.DWELL(DWELL)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (mod_en),
        .last_idx      (last_idx),
        .idx_nxt       (idx_nxt),
        .grp_start_nxt (grp_start_nxt),
        .idx_q         (idx_q),
        .first_q       (first_q),
        .active_q      (active)
    );

    ssm_level u_lvl (
        .idx   (idx_nxt),
        .k_val (k_val),
        .lvl   (lvl)
    );

    ssm_outreg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mod_en),
        .lvl       (lvl),
        .step_sh   (step_sh),
        .grp_start (grp_start_nxt),
        .dir_q     (step_dir),
        .mag_q     (step_mag),
        .track_q   (track_en)
    );

    // Checker state: signed offset history and the config behind each output
    logic signed [MAG_W+1:0] off_now, off_prev, off_diff;
    logic        [MAG_W+1:0] jump_abs, jump_lim;
    logic [LVL_W-1:0]        k_q, k_qq;
    logic [SHIFT_W-1:0]      sh_q, sh_qq;

    assign off_now  = step_dir ? -$signed({2'b00, step_mag}) : $signed({2'b00, step_mag});
    assign off_diff = off_now - off_prev;
    assign jump_abs = off_diff[MAG_W+1] ? -off_diff : off_diff;
    assign jump_lim = ((MAG_W+2)'(k_q) + 1'b1) << sh_q;

    // Track previous offset and the two most recent configurations
    always_ff @(posedge clk) begin : p_chk_hist
        if (!rst_n) begin
            off_prev <= '0;
            k_q <= '0; k_qq <= '0; sh_q <= '0; sh_qq <= '0;
        end else begin
            off_prev <= off_now;
            k_q  <= k_val; k_qq  <= k_q;
            sh_q <= step_sh; sh_qq <= sh_q;
        end
    end

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en) |=> (step_mag == '0 && !step_dir && track_en)); // R9
    AST_MAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (step_mag != '0)); // R3
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (step_mag <= (MAG_W'(k_q) << sh_q))); // R4
    AST_TRACK_AT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && track_en) |-> (idx_q[1:0] == 2'b00 && first_q)); // R8
    AST_TRACK_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && idx_q[1:0] == 2'b00 && first_q) |-> track_en); // R8
    AST_JUMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && k_q == k_qq && sh_q == sh_qq)
        |-> (jump_abs <= jump_lim)); // R6
endmodule

// File: tb/sim_spread_tri_mod.sv
// Sweep bench: every section select with every step select, two periods
// each, against the closed-form level; plus reset and idle cases.
module sim_spread_tri_mod;
    localparam int DWELL    = 3;
    localparam int CLK_HALF = 10;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic [2:0]  sec_sel = 3'd0;
    logic [2:0]  step_sel = 3'd0;
    logic        step_dir;
    logic [15:0] step_mag;
    logic        track_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    spread_tri_mod #(.DWELL(DWELL)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_en   (mod_en),
        .sec_sel  (sec_sel),
        .step_sel (step_sel),
        .step_dir (step_dir),
        .step_mag (step_mag),
        .track_en (track_en)
    );

    function automatic int exp_level(int n, int kk);
        int h = (n / 4) / 2;
        int p = kk - h;
        int q = h + 1;
        case (n % 4)
            0: return p;
            1: return -q;
            2: return -p;
            default: return q;
        endcase
    endfunction

    function automatic int obs_off();
        return step_dir ? -int'(step_mag) : int'(step_mag);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(string req);
        check(step_mag == 16'd0, req, "idle step_mag", int'(step_mag), 0);
        check(step_dir == 1'b0,  req, "idle step_dir", int'(step_dir), 0);
        check(track_en == 1'b1,  req, "idle track_en", int'(track_en), 1);
    endtask

    // Run n_cyc enabled cycles from a fresh start and compare every output
    task automatic run_window(int sel, int st, int n_cyc, bit full);
        int cnt = 8 << ((sel > 3) ? 3 : sel);
        int kk  = cnt / 4;
        int s   = 1 << st;
        int sum_grp = 0;
        int prev_off = 0;
        int max_jump = 0;
        int pulses = 0;
        bit have_prev = 1'b0;
        for (int k = 0; k < n_cyc; k++) begin
            int sec, eoff, aoff, jmp;
            bit etr;
            tick();
            sec  = (k / DWELL) % cnt;
            eoff = exp_level(sec, kk) * s;
            aoff = obs_off();
            etr  = ((k % (4 * DWELL)) == 0);
            // R2 R3 R4 R5: count, scaling, level order and dwell timing
            check(aoff == eoff, "R2 R3 R4 R5", "offset", aoff, eoff);
            check(track_en == etr, "R8", "track_en", int'(track_en), int'(etr));
            pulses += int'(track_en);
            if (k % DWELL == 0) begin
                if (have_prev) begin
                    jmp = (aoff > prev_off) ? aoff - prev_off : prev_off - aoff;
                    if (jmp > max_jump) max_jump = jmp;
                end
                prev_off  = aoff;
                have_prev = 1'b1;
                sum_grp  += aoff;
                if (sec % 4 == 3) begin
                    check(sum_grp == 0, "R7", "group sum", sum_grp, 0);
                    sum_grp = 0;
                end
            end
        end
        if (full) begin
            check(max_jump == (kk + 1) * s, "R6", "max neighbour jump", max_jump, (kk + 1) * s);
            check(pulses == n_cyc / (4 * DWELL), "R8", "pulses", pulses, n_cyc / (4 * DWELL));
        end
    endtask

    initial begin : p_watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog: actual=%0d cycles expected<%0d", WD_LIMIT, WD_LIMIT);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : p_main
        // R1: reset with enable high gives idle outputs
        rst_n = 1'b0; mod_en = 1'b1; sec_sel = 3'd1; step_sel = 3'd2;
        tick(); tick();
        check_idle("R1");
        rst_n = 1'b1;
        // R1: first cycle after release is sub-section 0 (+4 * 4 = 16)
        run_window(1, 2, 4 * DWELL, 1'b0);

        // Full sweep of both selects
        for (int sel = 0; sel < 8; sel++) begin
            for (int st = 0; st < 8; st++) begin
                int cnt = 8 << ((sel > 3) ? 3 : sel);
                mod_en = 1'b0; sec_sel = 3'(7 - sel); step_sel = 3'(7 - st);
                tick();
                check_idle("R9");           // idle, other selects ignored
                sec_sel = 3'(sel); step_sel = 3'(st);
                tick();
                check_idle("R9");
                mod_en = 1'b1;
                run_window(sel, st, 2 * cnt * DWELL, 1'b1);
            end
        end

        // R1: reset in mid-run, then restart from sub-section 0
        mod_en = 1'b0; sec_sel = 3'd2; step_sel = 3'd1;
        tick();
        mod_en = 1'b1;
        repeat (7) tick();
        rst_n = 1'b0;
        tick();
        check_idle("R1");
        rst_n = 1'b1;
        run_window(2, 1, 8 * DWELL, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule